// File: doc/BRIEF.md
# Per-Stream Single-Slot Link Buffer

This block sits on one incoming link between two neighbouring tiles of a statically scheduled stream network. Every stream owns exactly one word of storage, selected by stream number, and a valid flag. A word that arrives from the upstream neighbour goes into its stream's slot. It is acknowledged only when the slot is free, or when the slot is being emptied in the same cycle. If the slot is busy, the word is not acknowledged and the upstream node keeps it.

On the send side, a sequencer names one stream per cycle for transmission. If that stream's slot holds a word, the held word goes out. If the slot is empty and a fresh word for the same stream is arriving, the fresh word is passed straight through in the same cycle. When the downstream node does not acknowledge that fresh word, it is captured in the slot. A stream that was actually delivered in the previous cycle may not be sent again this cycle. Such a request is suppressed and the slot is left as it was.

Top module: `fcb_buffer`

## Requirements
- R1: After reset every slot is empty: a send request with no incoming word gives `out_vld`=0 for each of the 8 streams.
- R2: An incoming word for a stream whose slot is empty is acknowledged (`in_ack`=1) in the same cycle and stored. A later send of that stream outputs the word.
- R3: An incoming word for a stream whose slot is full, and which is not being delivered in that cycle, gets `in_ack`=0. The stored word is unchanged.
- R4: A word for a stream whose slot is delivered downstream in the same cycle (`out_vld`=1, `out_ack`=1) is acknowledged in that cycle and becomes the new slot content.
- R5: When a stream's slot is full and a fresh word for that stream arrives while it is being sent, the held word is the one driven on `out_data`.
- R6: A send of a stream whose slot is empty, while a word for that stream arrives, drives that word on `out_data` in the same cycle. If `out_ack`=1, the word is consumed and not stored.
- R7: If such a pass-through word gets `out_ack`=0, it is still acknowledged upstream and stored in the slot.
- R8: A send request for the stream that was delivered (`out_vld`=1 and `out_ack`=1) in the previous cycle gives `out_vld`=0, and its slot keeps its word.
- R9: A send that gets `out_ack`=0 leaves the slot full. The stream may be requested again in the next cycle.
- R10: The slots of different streams are independent under any mix of writes and sends. `out_stream` equals `rd_stream` whenever `out_vld`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Upstream word present |
| in_stream | input | 3 | Stream number of the upstream word (write address) |
| in_data | input | 32 | Upstream word |
| in_ack | output | 1 | Word taken this cycle |
| rd_en | input | 1 | Sequencer send request |
| rd_stream | input | 3 | Stream to send (read address) |
| out_vld | output | 1 | Word driven downstream |
| out_stream | output | 3 | Stream of the outgoing word |
| out_data | output | 32 | Outgoing word |
| out_ack | input | 1 | Downstream accepted the outgoing word |

## Verification
The hardest case to reach is the one where three things happen to a single stream in one cycle. The slot is full, the downstream node acknowledges the held word, and a new word for the same stream arrives. Only then is the new word acknowledged while its slot still reads as full. Random traffic on eight streams seldom lines these up, so directed steps first fill a slot and then issue the send and the new word together. A follow-up send of that stream in a later cycle shows which word was stored. The repeat guard is reached in a similar way: a delivered send is followed by a request for the same stream in the next cycle, with a fresh word offered as well.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  // true when a request names the stream delivered in the previous cycle
  function automatic logic is_repeat(input logic last_vld, input logic [7:0] last_s,
                                     input logic [7:0] req_s);
    return last_vld && (last_s == req_s);
  endfunction

  // upstream word may be taken: slot free, or its slot empties now
  function automatic logic may_accept(input logic slot_full, input logic draining_same);
    return !slot_full || draining_same;
  endfunction
endpackage

// File: rtl/fcb_store.sv
module fcb_store #(
  parameter int NS = 8,
  parameter int DW = 32,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_en,
  input  logic [SW-1:0] clr_idx,
  input  logic [SW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_full,
  output logic          wr_full,
  output logic [NS-1:0] valid_vec
);
  logic [DW-1:0] slot [NS];

  for (genvar g = 0; g < NS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
      end else if (wr_en && wr_idx == SW'(g)) begin
        valid_vec[g] <= 1'b1;
      end else if (clr_en && clr_idx == SW'(g)) begin
        valid_vec[g] <= 1'b0;
      end
    end
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == SW'(g)) slot[g] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];
  assign rd_full = valid_vec[rd_idx];
  assign wr_full = valid_vec[wr_idx];
endmodule

// File: rtl/fcb_sel.sv
module fcb_sel #(
  parameter int NS = 8,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [SW-1:0] rd_stream,
  input  logic          held,
  input  logic          fresh_match,
  input  logic          out_ack,
  output logic          hold_sel,
  output logic          byp_sel,
  output logic          guard_block
);
  import fcb_pkg::*;
  logic          last_vld;
  logic [SW-1:0] last_s;
  logic          go;

  assign guard_block = rd_en && is_repeat(last_vld, 8'(last_s), 8'(rd_stream));
  assign go          = rd_en && !guard_block;
  assign hold_sel    = go && held;
  assign byp_sel     = go && !held && fresh_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_vld <= 1'b0;
      last_s   <= '0;
    end else begin
      last_vld <= (hold_sel || byp_sel) && out_ack;
      last_s   <= rd_stream;
    end
  end
endmodule

// File: rtl/fcb_buffer.sv
module fcb_buffer #(
  parameter int NS = 8,
  parameter int DW = 32,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [SW-1:0] in_stream,
  input  logic [DW-1:0] in_data,
  output logic          in_ack,
  input  logic          rd_en,
  input  logic [SW-1:0] rd_stream,
  output logic          out_vld,
  output logic [SW-1:0] out_stream,
  output logic [DW-1:0] out_data,
  input  logic          out_ack
);
  import fcb_pkg::*;

  logic [DW-1:0] held_data;
  logic          held, wr_full, hold_sel, byp_sel, guard_block;
  logic          drain, drain_same, store_en, fresh_match;
  logic [NS-1:0] valid_vec;

  assign fresh_match = in_vld && (in_stream == rd_stream);

  fcb_sel #(.NS(NS)) u_sel (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_stream(rd_stream),
    .held(held), .fresh_match(fresh_match), .out_ack(out_ack),
    .hold_sel(hold_sel), .byp_sel(byp_sel), .guard_block(guard_block)
  );

  assign drain      = hold_sel && out_ack;
  assign drain_same = drain && (rd_stream == in_stream);
  assign in_ack     = in_vld && may_accept(wr_full, drain_same);
  assign store_en   = in_ack && !(byp_sel && out_ack);

  fcb_store #(.NS(NS), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(store_en), .wr_idx(in_stream), .wr_data(in_data),
    .clr_en(drain), .clr_idx(rd_stream), .rd_idx(rd_stream),
    .rd_data(held_data), .rd_full(held), .wr_full(wr_full), .valid_vec(valid_vec)
  );

  assign out_vld    = hold_sel || byp_sel;
  assign out_stream = rd_stream;
  assign out_data   = hold_sel ? held_data : in_data;
endmodule

// File: rtl/fcb_chk.sv
module fcb_chk #(
  parameter int NS = 8,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic [SW-1:0] in_stream,
  input logic          in_ack,
  input logic          rd_en,
  input logic [SW-1:0] rd_stream,
  input logic          out_vld,
  input logic [SW-1:0] out_stream,
  input logic          out_ack,
  input logic          byp_sel,
  input logic [NS-1:0] valid_vec
);
  // R2
  stored_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && !(byp_sel && out_ack) |=> valid_vec[$past(in_stream)]);
  // R3
  full_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && valid_vec[in_stream] && !(out_vld && out_ack && out_stream == in_stream)
    |-> !in_ack);
  // R5
  held_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && valid_vec[out_stream] |-> !byp_sel);
  // R8
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && out_ack |=> !(out_vld && out_stream == $past(out_stream)));
  // R9
  unacked_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_ack && !byp_sel |=> valid_vec[$past(out_stream)]);
  // R10
  stream_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> rd_en && out_stream == rd_stream);
endmodule

bind fcb_buffer fcb_chk #(.NS(NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_stream(in_stream), .in_ack(in_ack),
  .rd_en(rd_en), .rd_stream(rd_stream), .out_vld(out_vld), .out_stream(out_stream),
  .out_ack(out_ack), .byp_sel(byp_sel), .valid_vec(valid_vec)
);

// File: tb/sim_fcb_buffer.sv
`timescale 1ns/1ps
module sim_fcb_buffer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_vld = 1'b0, rd_en = 1'b0, out_ack = 1'b0;
  logic [2:0]  in_stream = '0, rd_stream = '0;
  logic [31:0] in_data = '0;
  logic        in_ack, out_vld;
  logic [2:0]  out_stream;
  logic [31:0] out_data;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference state: which streams hold a word, and what it is
  bit          m_full [8];
  logic [31:0] m_word [8];
  bit          m_sent_vld = 0;
  int          m_sent_s = 0;

  always #2 clk = ~clk;

  fcb_buffer u0 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_stream(in_stream),
    .in_data(in_data), .in_ack(in_ack), .rd_en(rd_en), .rd_stream(rd_stream),
    .out_vld(out_vld), .out_stream(out_stream), .out_data(out_data), .out_ack(out_ack));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit iv, int is, logic [31:0] idat, bit re, int rs, bit oa);
    bit blocked, from_slot, through, e_vld, e_ack, emptied;
    logic [31:0] e_data;
    @(negedge clk);
    in_vld = iv; in_stream = 3'(is); in_data = idat;
    rd_en = re; rd_stream = 3'(rs); out_ack = oa;
    #1;
    blocked   = re && m_sent_vld && (m_sent_s == rs);
    from_slot = re && !blocked && m_full[rs];
    through   = re && !blocked && !m_full[rs] && iv && (is == rs);
    e_vld     = from_slot || through;
    e_data    = from_slot ? m_word[rs] : idat;
    emptied   = from_slot && oa;
    e_ack     = iv && (!m_full[is] || (emptied && is == rs));
    chk(tag, "out_vld", 32'(out_vld), 32'(e_vld));
    chk(tag, "in_ack", 32'(in_ack), 32'(e_ack));
    if (e_vld) begin
      chk(tag, "out_data", out_data, e_data);
      chk(tag, "out_stream", 32'(out_stream), 32'(rs));
    end
    if (emptied) m_full[rs] = 0;
    if (e_ack && !(through && oa)) begin
      m_full[is] = 1; m_word[is] = idat;
    end
    m_sent_vld = e_vld && oa;
    m_sent_s = rs;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_full[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 empty after reset
    for (int s = 0; s < 8; s++) step("R1", 0, 0, 0, 1, s, 1);
    step("R1", 0, 0, 0, 0, 0, 0);
    // R2 store then send
    step("R2", 1, 3, 32'hA0A0_0003, 0, 0, 0);
    step("R2", 0, 0, 0, 1, 3, 1);
    // R3 full slot refuses
    step("R3", 1, 5, 32'hB0B0_0005, 0, 0, 0);
    step("R3", 1, 5, 32'hC0C0_0005, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 5, 1);
    // R9 unacked send keeps word, retry allowed next cycle
    step("R9", 1, 2, 32'hD0D0_0002, 0, 0, 0);
    step("R9", 0, 0, 0, 1, 2, 0);
    step("R9", 0, 0, 0, 1, 2, 1);
    // R8 repeat guard
    step("R8", 1, 1, 32'hE0E0_0001, 0, 0, 0);
    step("R8", 1, 4, 32'hF0F0_0004, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 1, 1);
    step("R8", 1, 1, 32'h1111_0001, 1, 1, 1);
    step("R8", 0, 0, 0, 1, 4, 1);
    step("R8", 0, 0, 0, 1, 1, 1);
    // R4 and R5 refill while draining, held word wins
    step("R4", 1, 6, 32'h6666_0001, 0, 0, 0);
    step("R5", 1, 6, 32'h6666_0002, 1, 6, 1);
    step("R4", 0, 0, 0, 1, 7, 1);
    step("R4", 0, 0, 0, 1, 6, 1);
    // R6 pass-through consumed
    step("R6", 1, 0, 32'h0707_0000, 1, 0, 1);
    step("R6", 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 1, 0, 1);
    // R7 pass-through not acked is kept
    step("R7", 0, 0, 0, 0, 0, 0);
    step("R7", 1, 0, 32'h0808_0000, 1, 0, 0);
    step("R7", 0, 0, 0, 1, 0, 1);
    // R10 mixed traffic on all streams
    for (int n = 0; n < 3000; n++)
      step("R10", 1'($urandom), int'($urandom_range(0, 7)), $urandom,
           1'($urandom), int'($urandom_range(0, 7)), 1'($urandom));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule